// File: doc/BRIEF.md
# General-Purpose Bidirectional Pin Port

This block is one parallel I/O port of up to eight pins. Software reaches it through a small register bus with an address, write data, a write strobe and combinational read data. Three locations hold the per-pin controls. The direction register chooses whether each pin drives or listens. The drive register does one of two jobs, depending on the direction bit of the same pin. The third location reads back the synchronized pad levels. The bus is a plain strobe interface: every access completes in its own cycle, and no back-pressure exists.

On the pad side the block produces an output enable, an output value and a pull-up enable for each pin. It samples the raw pad inputs through a two-stage synchronizer. A parameter sets how many of the port's bit positions carry real pins. The bit positions above that count read as zero, keep no state and never drive.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction and drive registers read 0, and every pin has pad_oe=0 and pad_pu=0, so every pin starts as a high-impedance input.
- R2: A write with bus_we=1 to address 0 (direction) loads the direction register at that clock edge, and a later read of address 0 returns the stored value.
- R3: A write with bus_we=1 to address 1 (drive) loads the drive register at that clock edge, and a later read of address 1 returns the stored value.
- R4: For a pin whose direction bit is 1, pad_oe is 1 and pad_do equals that pin's drive bit. For a pin whose direction bit is 0, pad_oe and pad_do are both 0.
- R5: For a pin whose direction bit is 0, pad_pu equals its drive bit. For a pin whose direction bit is 1, pad_pu is 0.
- R6: A read of address 2 returns the pad levels delayed by exactly two clock edges, whatever the direction setting.
- R7: Bit positions at or above PIN_CNT read 0 at every address, ignore writes and keep pad_oe, pad_do and pad_pu at 0, even when pad_in is 1 there.
- R8: Writes to address 2 or address 3 change no register, and a read of address 3 returns 0.
- R9: Each pin's direction and drive bits act independently of the other pins. With direction 0x01 and drive 0x03, pin 0 drives 1 and pin 1 has its pull-up enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 direction, 1 drive, 2 pad levels, 3 unused |
| bus_wdata | input | PORT_W | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | PORT_W | Read data for bus_addr, combinational |
| pad_in | input | PORT_W | Raw pad levels |
| pad_oe | output | PORT_W | Per-pin output enable |
| pad_do | output | PORT_W | Per-pin output value |
| pad_pu | output | PORT_W | Per-pin pull-up enable |

## Verification
The bench instantiates the port with five real pins, so masking of the upper positions is always under test. The direction and drive registers are tried with the following patterns:
- Mixed patterns such as 0xA5 with 0x1C. These show whether pad_do and pad_pu follow the right register bit for inputs and outputs alike, and whether the upper bits are dropped.
- All-ones writes. These expose any position above the pin count that keeps state or drives a pad.
- Single-pin patterns. These tell apart per-pin independence and accidental coupling between neighbouring pins.

The pad levels are changed away from the clock edge and read one edge and two edges later. This separates a correct two-stage delay from a one-stage or three-stage one. Writes to the read-only and unused addresses, followed by read-back of both registers, show that these writes are ignored.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    REG_DIR  = 2'd0,
    REG_DRV  = 2'd1,
    REG_PADS = 2'd2,
    REG_NONE = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int PORT_W  = 8,
  parameter int PIN_CNT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [PORT_W-1:0] wr_data,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] drv_q
);
  localparam logic [PORT_W-1:0] PIN_MASK = PORT_W'((1 << PIN_CNT) - 1);

  logic dir_hit, drv_hit;
  assign dir_hit = wr_en && (gpio_reg_e'(wr_addr) == REG_DIR);
  assign drv_hit = wr_en && (gpio_reg_e'(wr_addr) == REG_DRV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      drv_q <= '0;
    end else begin
      if (dir_hit) dir_q <= wr_data & PIN_MASK;
      if (drv_hit) drv_q <= wr_data & PIN_MASK;
    end
  end

  // R2
  p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0) |=> (dir_q == ($past(wr_data) & PIN_MASK)));
  // R3
  p_drv_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1) |=> (drv_q == ($past(wr_data) & PIN_MASK)));
  // R8
  p_dir_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 2'd0) |=> $stable(dir_q));
  p_drv_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 2'd1) |=> $stable(drv_q));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int PORT_W  = 8,
  parameter int PIN_CNT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pad_in,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pad_do,
  output logic [PORT_W-1:0] pad_pu
);
  localparam logic [PORT_W-1:0] PIN_MASK = PORT_W'((1 << PIN_CNT) - 1);

  logic [PORT_W-1:0] dir_q, drv_q, pads_s;

  gpio_regs #(.PORT_W(PORT_W), .PIN_CNT(PIN_CNT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .dir_q(dir_q), .drv_q(drv_q)
  );

  gpio_sync #(.W(PORT_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in & PIN_MASK), .sync_out(pads_s)
  );

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    if (i < PIN_CNT) begin : g_real
      assign pad_oe[i] = dir_q[i];
      assign pad_do[i] = dir_q[i] & drv_q[i];
      assign pad_pu[i] = ~dir_q[i] & drv_q[i];
    end else begin : g_absent
      assign pad_oe[i] = 1'b0;
      assign pad_do[i] = 1'b0;
      assign pad_pu[i] = 1'b0;
    end
  end

  always_comb begin
    unique case (gpio_reg_e'(bus_addr))
      REG_DIR:  bus_rdata = dir_q;
      REG_DRV:  bus_rdata = drv_q;
      REG_PADS: bus_rdata = pads_s;
      default:  bus_rdata = '0;
    endcase
  end

  // R5: no pin both drives and pulls up
  p_oe_pu_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pu) == '0);
  // R7
  p_rd_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~PIN_MASK) == '0);
  p_pad_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_do | pad_pu) & ~PIN_MASK) == '0);
  // R8
  p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   bus_addr = 2'd0;
  logic [W-1:0] bus_wdata = '0;
  logic         bus_we = 1'b0;
  logic [W-1:0] bus_rdata, pad_in, pad_oe, pad_do, pad_pu;
  int checks = 0;
  int errors = 0;

  initial pad_in = '0;
  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port #(.PORT_W(W), .PIN_CNT(5)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [W-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [W-1:0] d;
    bus_read(2'd0, d); check("R1 dir", d, 8'h00);
    bus_read(2'd1, d); check("R1 drv", d, 8'h00);
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_pu", pad_pu, 8'h00);
  endtask

  task automatic t_mixed;
    logic [W-1:0] d;
    bus_write(2'd0, 8'hA5);
    bus_read(2'd0, d); check("R2 dir readback", d, 8'h05);
    check("R4 pad_oe", pad_oe, 8'h05);
    bus_write(2'd1, 8'h1C);
    bus_read(2'd1, d); check("R3 drv readback", d, 8'h1C);
    check("R4 pad_do", pad_do, 8'h04);
    check("R5 pad_pu", pad_pu, 8'h18);
  endtask

  task automatic t_sync;
    logic [W-1:0] d;
    @(negedge clk); pad_in = 8'h0B;
    @(negedge clk);
    bus_read(2'd2, d); check("R6 one edge", d, 8'h00);
    @(negedge clk);
    bus_read(2'd2, d); check("R6 two edges", d, 8'h0B);
    bus_write(2'd0, 8'h1F);
    pad_in = 8'h15;
    @(negedge clk); @(negedge clk);
    bus_read(2'd2, d); check("R6 all outputs", d, 8'h15);
  endtask

  task automatic t_unimpl;
    logic [W-1:0] d;
    bus_write(2'd0, 8'hFF);
    bus_read(2'd0, d); check("R7 dir mask", d, 8'h1F);
    check("R7 pad_oe", pad_oe, 8'h1F);
    bus_write(2'd1, 8'hE0);
    bus_read(2'd1, d); check("R7 drv mask", d, 8'h00);
    check("R7 pad_do", pad_do, 8'h00);
    pad_in = 8'hFF;
    @(negedge clk); @(negedge clk);
    bus_read(2'd2, d); check("R7 pads mask", d, 8'h1F);
  endtask

  task automatic t_ignored;
    logic [W-1:0] d;
    bus_write(2'd0, 8'h0A);
    bus_write(2'd1, 8'h11);
    bus_write(2'd2, 8'h00);
    bus_write(2'd3, 8'hFF);
    bus_read(2'd0, d); check("R8 dir kept", d, 8'h0A);
    bus_read(2'd1, d); check("R8 drv kept", d, 8'h11);
    bus_read(2'd3, d); check("R8 unused reads 0", d, 8'h00);
  endtask

  task automatic t_indep;
    bus_write(2'd0, 8'h01);
    bus_write(2'd1, 8'h03);
    check("R9 pad_do", pad_do, 8'h01);
    check("R9 pad_pu", pad_pu, 8'h02);
    check("R9 pad_oe", pad_oe, 8'h01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mixed();
    t_sync();
    t_unimpl();
    t_ignored();
    t_indep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule